// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces, one per clock, the column addresses that make up a single SDRAM burst. A start strobe captures a 9-bit starting column, a burst length code, an ordering select and the write/single-write qualifiers. From the next clock on, the block presents one column per cycle with a valid flag. A fixed-length burst marks its final column with a last flag.

Fixed bursts of 2, 4 or 8 beats keep the column bits above the burst field fixed. Only the low bits change, either by counting up with wrap-around or by XOR with the beat index. A full-page burst walks all 512 columns in order and wraps past the top. It keeps running until a terminate input stops it. A controller drives the command bus and data path from the valid, last and column outputs. This block does neither of those jobs.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_ni is low, valid_o and last_o are low, and they drop at once when reset is asserted in the middle of a burst.
- R2: One clock after a clock edge that samples start_i high, valid_o is high and col_o equals the captured start column (beat 0), in every mode.
- R3: The 3-bit length code maps 0 to 1 beat, 1 to 2, 2 to 4, 3 to 8 and 7 to full page. Codes 4, 5 and 6 give 1 beat. valid_o stays high for exactly the burst length.
- R4: With il_type_i = 0 and a fixed length BL, beat n carries the start column's low log2(BL) bits plus n, modulo BL, and the upper bits unchanged.
- R5: With il_type_i = 1 and a fixed length BL, beat n carries the start column's low log2(BL) bits XOR n, and the upper bits unchanged.
- R6: last_o is high on the final beat of a fixed-length burst and on no other beat. valid_o is low on the following clock unless a new start is sampled.
- R7: A full-page burst always uses sequential order, whatever il_type_i is. Each beat is the previous column plus 1 modulo 512, and last_o never asserts.
- R8: During a full-page burst, term_i high at a clock edge makes the beat present at that edge the final one, so valid_o is low on the next clock. term_i has no effect on a fixed-length burst.
- R9: When wr_i and single_wr_i are both high at the start, the burst is one beat long, whatever the length code.
- R10: A start sampled during an active burst abandons that burst, and the next clock shows beat 0 of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a burst with the inputs below |
| start_col_i | input | 9 | Starting column address |
| bl_code_i | input | 3 | Burst length code (see R3) |
| il_type_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| wr_i | input | 1 | The burst is a write |
| single_wr_i | input | 1 | Single-word write mode |
| term_i | input | 1 | Stops a full-page burst |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is present |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
A table drives bursts with starting columns whose low bits sit at zero, mid-field and all-ones, so a bad wrap or a missing XOR changes the order seen. The same column is run as sequential and as interleaved to tell the two orderings apart. Write with and without single-write mode tells the one-beat override from the length code, and a reserved code checks the fallback to one beat. Full-page runs start near the top of the column space so the 512 wrap is crossed, one with the interleave bit set. Directed cases cover a terminate held through a fixed burst, a restart in the middle of a burst, and reset in the middle of a burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned COL_W = 9;
  localparam int unsigned CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W_P = COL_W
) (
  input  logic [CODE_W-1:0] bl_code_i,
  input  logic              wr_i,
  input  logic              single_wr_i,
  output logic [COL_W_P-1:0] mask_o,
  output logic              full_o
);
  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    if (!(wr_i && single_wr_i)) begin
      case (bl_code_e'(bl_code_i))
        BL_2:    mask_o = COL_W_P'(1);
        BL_4:    mask_o = COL_W_P'(3);
        BL_8:    mask_o = COL_W_P'(7);
        BL_PAGE: begin
          mask_o = '1;
          full_o = 1'b1;
        end
        default: mask_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W_P = COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COL_W_P-1:0] start_col_i,
  input  logic [COL_W_P-1:0] mask_i,
  input  logic               full_i,
  input  logic               il_i,
  input  logic               term_i,
  output logic               busy_o,
  output logic [COL_W_P-1:0] base_o,
  output logic [COL_W_P-1:0] cnt_o,
  output logic [COL_W_P-1:0] mask_o,
  output logic               full_o,
  output logic               il_o,
  output logic               last_o
);
  logic               busy_q, full_q, il_q;
  logic [COL_W_P-1:0] base_q, cnt_q, mask_q;
  logic               fixed_end, page_end;

  assign fixed_end = busy_q && !full_q && (cnt_q == mask_q);
  assign page_end  = busy_q && full_q && term_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      il_q   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      full_q <= full_i;
      il_q   <= il_i && !full_i;  // full page is sequential only
      base_q <= start_col_i;
      cnt_q  <= '0;
      mask_q <= mask_i;
    end else if (busy_q) begin
      if (fixed_end || page_end) busy_q <= 1'b0;
      else cnt_q <= cnt_q + COL_W_P'(1);
    end
  end

  assign busy_o = busy_q;
  assign base_o = base_q;
  assign cnt_o  = cnt_q;
  assign mask_o = mask_q;
  assign full_o = full_q;
  assign il_o   = il_q;
  assign last_o = fixed_end;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W_P = COL_W
) (
  input  logic [COL_W_P-1:0] base_i,
  input  logic [COL_W_P-1:0] cnt_i,
  input  logic [COL_W_P-1:0] mask_i,
  input  logic               il_i,
  output logic [COL_W_P-1:0] col_o
);
  logic [COL_W_P-1:0] sum;
  assign sum = base_i + cnt_i;

  // carries only move upward, so masked low bits of sum wrap within the block
  for (genvar b = 0; b < COL_W_P; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (il_i ? (base_i[b] ^ cnt_i[b]) : sum[b])
                                : base_i[b];
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W_P = COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COL_W_P-1:0] start_col_i,
  input  logic [CODE_W-1:0]  bl_code_i,
  input  logic               il_type_i,
  input  logic               wr_i,
  input  logic               single_wr_i,
  input  logic               term_i,
  output logic [COL_W_P-1:0] col_o,
  output logic               valid_o,
  output logic               last_o
);
  logic [COL_W_P-1:0] dec_mask, base_q, cnt_q, mask_q;
  logic               dec_full, full_q, il_q, busy_q;

  burst_len_decode #(.COL_W_P(COL_W_P)) u_dec (
    .bl_code_i  (bl_code_i),
    .wr_i       (wr_i),
    .single_wr_i(single_wr_i),
    .mask_o     (dec_mask),
    .full_o     (dec_full)
  );

  burst_beat_ctrl #(.COL_W_P(COL_W_P)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .start_col_i(start_col_i),
    .mask_i     (dec_mask),
    .full_i     (dec_full),
    .il_i       (il_type_i),
    .term_i     (term_i),
    .busy_o     (busy_q),
    .base_o     (base_q),
    .cnt_o      (cnt_q),
    .mask_o     (mask_q),
    .full_o     (full_q),
    .il_o       (il_q),
    .last_o     (last_o)
  );

  burst_addr_gen #(.COL_W_P(COL_W_P)) u_gen (
    .base_i(base_q),
    .cnt_i (cnt_q),
    .mask_i(mask_q),
    .il_i  (il_q),
    .col_o (col_o)
  );

  assign valid_o = busy_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int unsigned COL_W_P = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [COL_W_P-1:0] start_col_i,
  input logic               term_i,
  input logic [COL_W_P-1:0] col_o,
  input logic               valid_o,
  input logic               last_o,
  input logic               full_q
);
  a_r2_first_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == $past(start_col_i)));

  a_r6_last_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o && !full_q);

  a_r6_idle_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !start_i |=> !valid_o);

  a_r3_fixed_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !full_q && !last_o && !start_i |=> valid_o);

  a_r7_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q && !term_i && !start_i |=>
      valid_o && (col_o == COL_W_P'($past(col_o) + COL_W_P'(1))));

  a_r8_term_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q && term_i && !start_i |=> !valid_o);
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W_P(COL_W_P)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .term_i     (term_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o),
  .full_q     (full_q)
);

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       il_type_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       single_wr_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  burst_col_seq uut (.*);

  // [14:6] column, [5:3] length code, [2] interleave, [1] write, [0] single write
  localparam logic [14:0] VECS [0:11] = '{
    {9'h005, 3'd0, 1'b0, 1'b0, 1'b0},
    {9'h005, 3'd1, 1'b0, 1'b0, 1'b0},
    {9'h00D, 3'd2, 1'b0, 1'b0, 1'b0},
    {9'h0A6, 3'd3, 1'b0, 1'b0, 1'b0},
    {9'h0A6, 3'd3, 1'b1, 1'b0, 1'b0},
    {9'h133, 3'd2, 1'b1, 1'b0, 1'b0},
    {9'h1FF, 3'd1, 1'b1, 1'b0, 1'b0},
    {9'h07B, 3'd5, 1'b0, 1'b0, 1'b0},
    {9'h0A6, 3'd3, 1'b0, 1'b1, 1'b1},
    {9'h0A6, 3'd3, 1'b0, 1'b1, 1'b0},
    {9'h1FC, 3'd7, 1'b1, 1'b0, 1'b0},
    {9'h010, 3'd7, 1'b0, 1'b0, 1'b0}
  };

  function automatic int exp_len(logic [2:0] code, logic wr, logic sw);
    if (wr && sw) return 1;
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] exp_col(logic [8:0] s, int len, logic il, int n);
    logic [8:0] m, off, low;
    if (len == 512) return 9'((int'(s) + n) % 512);
    m   = 9'(len - 1);
    off = 9'(n);
    low = il ? ((s ^ off) & m) : (9'(s + off) & m);
    return (s & ~m) | low;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act {valid,last,col}=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_burst(input logic [8:0] col, input logic [2:0] code, input logic il,
                           input logic wr, input logic sw, input logic term_hold, input string tag);
    int len, nb;
    logic [10:0] e;
    len = exp_len(code, wr, sw);
    nb  = (len == 512) ? ((col >= 9'h100) ? 520 : 20) : len;
    start_col_i = col; bl_code_i = code; il_type_i = il; wr_i = wr; single_wr_i = sw;
    term_i = term_hold; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int n = 0; n < nb; n++) begin
      e = {1'b1, (len != 512) && (n == nb - 1), exp_col(col, len, il && len != 512, n)};
      chk({valid_o, last_o, col_o} === e, tag, {valid_o, last_o, col_o}, e);
      if (len == 512 && n == nb - 1) term_i = 1'b1;
      @(negedge clk_i);
    end
    chk(valid_o === 1'b0 && last_o === 1'b0, (len == 512) ? "R8" : "R6",
        {valid_o, last_o, col_o}, 11'h000 | {2'b00, col_o});
    term_i = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0 && last_o === 1'b0, "R1", {valid_o, last_o, col_o}, {2'b00, col_o});
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 12; i++) begin
      logic [14:0] v;
      string tag;
      v = VECS[i];
      if (v[1] && v[0])            tag = "R9";
      else if (v[5:3] == 3'd7)     tag = "R7";
      else if (v[5:3] inside {[3'd4:3'd6]}) tag = "R3";
      else if (v[2])               tag = "R5";
      else                         tag = "R4";
      run_burst(v[14:6], v[5:3], v[2], v[1], v[0], 1'b0, tag);
      @(negedge clk_i);
    end

    // R8: terminate held through a fixed burst has no effect
    run_burst(9'h0C2, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

    // R2 / R10: restart mid-burst
    start_col_i = 9'h005; bl_code_i = 3'd3; il_type_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(valid_o === 1'b1 && col_o === 9'h005, "R2", {valid_o, last_o, col_o}, {2'b10, 9'h005});
    repeat (2) @(negedge clk_i);
    run_burst(9'h1F0, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R10");

    // R1: asynchronous reset mid-burst
    start_col_i = 9'h040; bl_code_i = 3'd7; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(valid_o === 1'b0 && last_o === 1'b0, "R1", {valid_o, last_o, col_o}, {2'b00, col_o});
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R1", {valid_o, last_o, col_o}, {2'b00, col_o});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule